// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is the master side of a PHY management link. Software writes a single 32-bit command word into the engine's data register. That word carries the start pattern, the opcode, a 5-bit PHY address, a 5-bit register address, the turnaround pair and 16 data bits. If the engine is idle and has a non-zero clock speed programmed, the write starts one serial frame on the management clock and data pins. The engine always sends a full 32-bit preamble of ones first. It then sends the command word with the most significant bit first.

During a read, the engine releases the data pin for the turnaround and data bits. It samples the PHY's answer on the rising edges of the management clock. When the frame ends, the 16 returned bits replace the low half of the data register. In all cases the engine raises a completion event flag, which software clears by writing a one to it. The management clock runs only while a frame is in progress. Each of its half periods lasts the programmed speed value in system clock cycles, so its frequency is the system clock divided by twice that value.

The controller moves through five states:
- `ST_IDLE` goes to `ST_PREAMBLE` when a command is accepted.
- `ST_PREAMBLE` goes to `ST_HEADER` after the falling edge that ends bit 31.
- `ST_HEADER` goes to `ST_TURN` after bit 45.
- `ST_TURN` goes to `ST_DATA` after bit 47.
- `ST_DATA` returns to `ST_IDLE` after bit 63, which is where completion is signalled.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset `busy`, `mdc`, `mdio_oe`, `done_evt` and `data_reg` are all 0, and the speed value is 0.
- R2: A command write accepted while idle with a non-zero speed stores the word in `data_reg` and sets `busy` at the next clock edge.
- R3: A frame is 64 bits: 32 ones, then command bits 31 down to 0. The field layout is start [31:30], opcode [29:28] (10 = read, 01 = write), PHY address [27:23], register address [22:18], turnaround [17:16] and data [15:0]. Each bit is stable across one rising edge of `mdc`.
- R4: The first rising edge of `mdc` comes speed cycles after the accepting edge. Every half period of `mdc` is speed cycles long. `mdc` is low whenever `busy` is low.
- R5: With opcode 10, `mdio_oe` is low for frame bits 46 to 63. With any other opcode it is high for all 64 bits. In both cases it is high for bits 0 to 45 and low while idle.
- R6: For a read, the bits on `mdio_i` at the rising edges of bits 48 to 63 (MSB first) become `data_reg[15:0]` at completion, and `data_reg[31:16]` keeps the command. For other opcodes `data_reg` keeps the written word.
- R7: The 64th falling edge of `mdc`, which is 128 × speed cycles after the accepting edge, clears `busy` and sets `done_evt`.
- R8: An event write with `evt_wdata` = 1 clears `done_evt`. An event write with `evt_wdata` = 0 leaves it set.
- R9: A command write while `busy` is ignored: no restart, and `data_reg` is unchanged.
- R10: While the speed value is 0, command writes are ignored and `mdc` stays low. A speed write while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe for the command/data register |
| cmd_wdata | input | 32 | Command word |
| evt_wr | input | 1 | Write strobe for the event flag |
| evt_wdata | input | 1 | 1 clears the completion flag |
| speed_wr | input | 1 | Write strobe for the speed value |
| speed_wdata | input | SPD_W | Half-period length in system cycles, 0 disables |
| data_reg | output | 32 | Command/data register contents |
| done_evt | output | 1 | Completion event flag |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions check these rules on every cycle:
- `mdc` stays low outside a frame.
- `data_reg` and the speed value cannot change during a frame, except for the read capture at completion.
- The completion flag can only rise out of a busy cycle.
- The preamble drives a one.

Only the bench scenarios can show that the serial bit order matches the command word and that the half periods equal the programmed speed. The same holds for releasing the pin on exactly bits 46 to 63 of a read and for the PHY's reply arriving in the low half of the register. The sweep covers three speeds, read, write and a non-standard opcode, and several address and data patterns. Some frames also receive command and speed writes in mid-frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int HDR_LAST   = 45;
    localparam int TURN_LAST  = 47;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    localparam logic [1:0] OPC_READ = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_e;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SPD_W-1:0] speed,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic [SPD_W-1:0] cnt_q;
    logic             mdc_q;
    logic             term;

    assign term = (speed != '0) && (cnt_q == speed - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run || speed == '0) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (term) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc       = mdc_q;
    assign rise_tick = run && term && !mdc_q;
    assign fall_tick = run && term && mdc_q;

    AST_HALT_LOWERS_MDC: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc); // R4

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] cmd,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done_pulse,
    output logic [15:0] rd_data
);

    mdio_state_e              state_q, state_d;
    logic [BIT_W-1:0]         bit_q;
    logic [FRAME_BITS-1:0]    shift_q;
    logic                     is_rd_q;
    logic [15:0]              cap_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_tick && bit_q == BIT_W'(PRE_BITS - 1)) state_d = ST_HEADER;
            ST_HEADER:   if (fall_tick && bit_q == BIT_W'(HDR_LAST))     state_d = ST_TURN;
            ST_TURN:     if (fall_tick && bit_q == BIT_W'(TURN_LAST))    state_d = ST_DATA;
            ST_DATA:     if (fall_tick && bit_q == BIT_W'(FRAME_BITS - 1)) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            shift_q <= '0;
            is_rd_q <= 1'b0;
            cap_q   <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                bit_q   <= '0;
                shift_q <= {{PRE_BITS{1'b1}}, cmd};
                is_rd_q <= (cmd[29:28] == OPC_READ);
                cap_q   <= '0;
            end
        end else begin
            if (rise_tick && state_q == ST_DATA && is_rd_q)
                cap_q <= {cap_q[14:0], mdio_i};
            if (fall_tick) begin
                bit_q   <= bit_q + 1'b1;
                shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                mdio_oe = 1'b0;
                mdio_o  = 1'b1;
            end
            ST_PREAMBLE, ST_HEADER: begin
                mdio_oe = 1'b1;
                mdio_o  = shift_q[FRAME_BITS-1];
            end
            ST_TURN, ST_DATA: begin
                mdio_oe = !is_rd_q;
                mdio_o  = shift_q[FRAME_BITS-1];
            end
            default: begin
                mdio_oe = 1'b0;
                mdio_o  = 1'b1;
            end
        endcase
    end

    assign busy       = (state_q != ST_IDLE);
    assign done_pulse = (state_q == ST_DATA) && fall_tick && (bit_q == BIT_W'(FRAME_BITS - 1));
    assign rd_data    = cap_q;

    AST_PREAMBLE_DRIVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PREAMBLE) |-> (mdio_oe && mdio_o)); // R3

    AST_DONE_LEAVES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !busy); // R7

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [31:0]      cmd_wdata,
    input  logic             evt_wr,
    input  logic             evt_wdata,
    input  logic             speed_wr,
    input  logic [SPD_W-1:0] speed_wdata,
    output logic [31:0]      data_reg,
    output logic             done_evt,
    output logic             busy,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    logic [SPD_W-1:0] speed_q;
    logic [31:0]      data_q;
    logic             done_q;
    logic             accept;
    logic             rise_tick, fall_tick, done_pulse;
    logic [15:0]      rd_data;

    assign accept = cmd_wr && !busy && (speed_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 speed_q <= '0;
        else if (speed_wr && !busy) speed_q <= speed_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (accept)
            data_q <= cmd_wdata;
        else if (done_pulse && data_q[29:28] == OPC_READ)
            data_q <= {data_q[31:16], rd_data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  done_q <= 1'b0;
        else if (done_pulse)         done_q <= 1'b1;
        else if (evt_wr && evt_wdata) done_q <= 1'b0;
    end

    mdio_clk_div #(.SPD_W(SPD_W)) clk_div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .speed     (speed_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm frame_fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .cmd        (cmd_wdata),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mdio_i     (mdio_i),
        .busy       (busy),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done_pulse (done_pulse),
        .rd_data    (rd_data)
    );

    assign data_reg = data_q;
    assign done_evt = done_q;

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R4

    AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_pulse) |=> $stable(data_reg)); // R9

    AST_SPEED_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(speed_q)); // R10

    AST_ZERO_SPEED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_q == '0 && !busy) |=> !busy); // R10

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_evt) |-> $past(busy)); // R7

endmodule

// File: tb/mdio_mgmt_engine_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_engine_tb_top;

    localparam int SPD_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_wr = 1'b0;
    logic [31:0]      cmd_wdata = '0;
    logic             evt_wr = 1'b0;
    logic             evt_wdata = 1'b0;
    logic             speed_wr = 1'b0;
    logic [SPD_W-1:0] speed_wdata = '0;
    logic [31:0]      data_reg;
    logic             done_evt, busy, mdc, mdio_o, mdio_oe;
    logic             mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mdio_mgmt_engine #(.SPD_W(SPD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .evt_wr(evt_wr), .evt_wdata(evt_wdata), .speed_wr(speed_wr),
        .speed_wdata(speed_wdata), .data_reg(data_reg), .done_evt(done_evt),
        .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_speed(input int s);
        @(negedge clk);
        speed_wr = 1'b1;
        speed_wdata = SPD_W'(s);
        @(negedge clk);
        speed_wr = 1'b0;
    endtask

    task automatic evt_write(input bit v);
        @(negedge clk);
        evt_wr = 1'b1;
        evt_wdata = v;
        @(negedge clk);
        evt_wr = 1'b0;
    endtask

    task automatic run_txn(input int s, input logic [31:0] cmd, input logic [15:0] resp,
                           input bit disturb);
        logic rec_o  [64];
        logic rec_oe [64];
        int   cyc, last, rises, bad_half, bad_bits, bad_oe;
        logic prev;
        bit   rd;
        rd = (cmd[29:28] == 2'b10);
        mdio_i = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = cmd;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", busy, 1);
        chk(data_reg == cmd, "R2 data_reg holds command", data_reg, cmd);
        cyc = 0; last = 0; rises = 0; bad_half = 0; prev = 1'b0;
        while (busy && cyc < 4000) begin
            if (disturb && cyc == 3) begin
                cmd_wr = 1'b1; cmd_wdata = ~cmd;
                speed_wr = 1'b1; speed_wdata = SPD_W'(s + 4);
            end
            if (disturb && cyc == 4) begin
                cmd_wr = 1'b0; speed_wr = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (mdc != prev) begin
                if (cyc - last != s) bad_half++;
                last = cyc;
                if (mdc && rises < 64) begin
                    rec_o[rises]  = mdio_o;
                    rec_oe[rises] = mdio_oe;
                    rises++;
                    mdio_i = (rises >= 48 && rises < 64) ? resp[63 - rises] : 1'b1;
                end
                prev = mdc;
            end
        end
        chk(cyc == 128 * s, "R7 frame duration", cyc, 128 * s);
        chk(bad_half == 0, disturb ? "R10 half period under speed write" : "R4 half period",
            bad_half, 0);
        chk(rises == 64, "R3 rising edge count", rises, 64);
        bad_bits = 0; bad_oe = 0;
        for (int i = 0; i < rises; i++) begin
            bit exp_oe, exp_b;
            exp_oe = !(rd && i >= 46);
            exp_b  = (i < 32) ? 1'b1 : cmd[63 - i];
            if (rec_oe[i] !== exp_oe) bad_oe++;
            if (exp_oe && rec_o[i] !== exp_b) bad_bits++;
        end
        chk(bad_bits == 0, "R3 serial bit order", bad_bits, 0);
        chk(bad_oe == 0, "R5 output enable pattern", bad_oe, 0);
        chk(!busy && done_evt, "R7 done set, busy cleared", {busy, done_evt}, 2'b01);
        chk(!mdc && !mdio_oe, "R4 idle pins", {mdc, mdio_oe}, 0);
        if (rd)
            chk(data_reg == {cmd[31:16], resp}, disturb ? "R9 R6 read data" : "R6 read data",
                data_reg, {cmd[31:16], resp});
        else
            chk(data_reg == cmd, disturb ? "R9 data kept" : "R6 write data kept", data_reg, cmd);
        evt_write(1'b0);
        chk(done_evt == 1'b1, "R8 zero write keeps flag", done_evt, 1);
        evt_write(1'b1);
        chk(done_evt == 1'b0, "R8 one write clears flag", done_evt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && mdc == 0 && mdio_oe == 0 && done_evt == 0, "R1 reset outputs",
            {busy, mdc, mdio_oe, done_evt}, 0);
        chk(data_reg == 0, "R1 reset data_reg", data_reg, 0);

        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = 32'h6012_3456;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 0 && mdc == 0, "R10 zero speed ignores command", {busy, mdc}, 0);
        chk(data_reg == 0, "R10 zero speed data_reg", data_reg, 0);

        for (int s = 1; s <= 3; s++) begin
            set_speed(s);
            for (int op = 0; op < 2; op++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [4:0]  pa, ra;
                    logic [15:0] d, r;
                    logic [1:0]  opc;
                    opc = op ? 2'b10 : 2'b01;
                    pa  = 5'((k * 11 + s) & 31);
                    ra  = 5'((k * 7 + 3 * s) & 31);
                    d   = 16'hA5C3 ^ 16'(k * 16'h1111) ^ 16'(s);
                    r   = 16'h3C5A + 16'(k * 16'h0101) + 16'(s * 7);
                    run_txn(s, {2'b01, opc, pa, ra, 2'b10, d}, r, k == 1);
                end
            end
        end
        set_speed(2);
        run_txn(2, {2'b01, 2'b11, 5'd9, 5'd17, 2'b10, 16'h8001}, 16'hFFFF, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule